// File: doc/BRIEF.md
# Interleaved SECDED Protected Entry Storage

This block holds entries for a lookup table or a plain memory and keeps them safe against soft errors. Each stored word is divided by bit parity: the bits at even positions form one half and the bits at odd positions form the other. Each half is given its own single-error-correct, double-error-detect code. An upset that flips two neighbouring bits therefore touches each code once, and both flips are repaired.

The check bits are not kept beside the data. They sit in a separate check store that decodes its own row address. The write address is also mixed into the check bits, so a read that finds check bits written for a different row reports an uncorrectable error instead of returning bad data. A read returns corrected data and two status flags one clock after the address is given. The test inputs let a bench flip stored bits in either store, and can steer one write of check bits to the next row up.

Top module: `ilv_secded_store`

## Requirements
- R1: A word written to a row is read back unchanged, with both flags low. `rd_valid` rises exactly one clock after `rd_en` is sampled high, and the data and flags are valid in that same cycle.
- R2: One flipped data bit at any position is repaired. The read returns the written word with `rd_corrected` high and `rd_uncorrectable` low.
- R3: Two flipped bits at adjacent positions i and i+1 are both repaired. Even positions belong to one half and odd positions to the other. The read returns the written word with `rd_corrected` high and `rd_uncorrectable` low.
- R4: Two flipped bits in the same half raise `rd_uncorrectable`. That half is returned raw, with both flips visible. The other half is still decoded on its own, and a single flip there still sets `rd_corrected`.
- R5: One flipped stored check bit leaves the data intact and sets `rd_corrected`. In the check word, bits [5:0] belong to the even half and bits [11:6] to the odd half. Within each half, bit 5 is the overall parity bit and bits 4:0 are the Hamming bits.
- R6: When `tst_skew_wr` is high during a write, the check bits go to row (`wr_addr`+1) mod DEPTH, while the data goes to `wr_addr`. If that row holds the same data word, a read of it returns the raw word with `rd_uncorrectable` high and `rd_corrected` low. This also holds when the next row wraps around to row 0.
- R7: While `rst` is high and on the first clock after it, `rd_valid`, `rd_data`, `rd_corrected` and `rd_uncorrectable` are all zero.
- R8: When `rd_en` is low, `rd_valid` is low on the next clock, and `rd_data` and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write row |
| wr_data | input | 32 | Word to store |
| tst_skew_wr | input | 1 | Test: this write places its check bits one row up |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read row |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Corrected read word |
| rd_corrected | output | 1 | A half needed a single-bit repair |
| rd_uncorrectable | output | 1 | A half held an error it cannot repair |
| flt_en | input | 1 | Test: apply flip masks to a stored row |
| flt_addr | input | AW | Test: row to corrupt |
| flt_data_mask | input | 32 | Test: data bits to invert |
| flt_chk_mask | input | 12 | Test: check bits to invert |

## Verification
The hardest case to reach is check bits that are internally consistent but stored at the wrong row. A normal write can never produce it. The stimulus first fills a row with a known word. It then writes the same word to the row below with the skew input raised, so the row above ends up holding check bits built for the address below. Only the address term then differs in the syndrome, and the same setup is repeated at the top row to cover the wrap to row 0. Bit flips are applied through the fault port, either to a single bit, to adjacent pairs, to pairs within one half, or to one check bit, between a write and the read that observes them.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_HALF = 2;
    localparam int HALF_W   = WORD_W / NUM_HALF;
    localparam int ADDR_W   = 4;
    localparam int HAM_R    = 5;
    localparam int CHK_W    = HAM_R + 1;
    localparam int CHK_TOT  = NUM_HALF * CHK_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [HAM_R-1:0]  syn_t;
    typedef logic [ADDR_W-1:0] fold_t;

    typedef struct packed {
        logic ovr;
        syn_t ham;
    } chk_t;

    typedef struct packed {
        half_t data;
        logic  fixed;
        logic  bad;
    } dec_t;

    // Address columns: bit 0 plus exactly one higher bit; independent set.
    function automatic logic is_addr_col(input syn_t c);
        return c[0] && ($countones(c) == 2);
    endfunction

    function automatic syn_t addr_col(input int k);
        return syn_t'(1) | (syn_t'(1) << (k + 1));
    endfunction

    // Data columns: weight >= 2, skipping the address columns.
    function automatic syn_t data_col(input int idx);
        int   n;
        syn_t r;
        n = 0;
        r = '0;
        for (int v = 1; v < (1 << HAM_R); v++) begin
            if ($countones(syn_t'(v)) > 1 && !is_addr_col(syn_t'(v))) begin
                if (n == idx) r = syn_t'(v);
                n++;
            end
        end
        return r;
    endfunction

    function automatic syn_t ham_bits(input half_t d, input fold_t a);
        syn_t c;
        c = '0;
        for (int i = 0; i < HALF_W; i++)
            if (d[i]) c ^= data_col(i);
        for (int k = 0; k < ADDR_W; k++)
            if (a[k]) c ^= addr_col(k);
        return c;
    endfunction

    function automatic chk_t encode(input half_t d, input fold_t a);
        chk_t r;
        r.ham = ham_bits(d, a);
        r.ovr = (^d) ^ (^r.ham);
        return r;
    endfunction

    function automatic dec_t decode(input half_t d, input chk_t c, input fold_t a);
        dec_t r;
        syn_t syn;
        logic odd;
        logic hit;
        syn     = ham_bits(d, a) ^ c.ham;
        odd     = (^d) ^ (^c.ham) ^ c.ovr;
        r.data  = d;
        r.fixed = 1'b0;
        r.bad   = 1'b0;
        hit     = 1'b0;
        if (odd) begin
            if (syn == '0 || $countones(syn) == 1) begin
                r.fixed = 1'b1;
            end else begin
                for (int i = 0; i < HALF_W; i++) begin
                    if (data_col(i) == syn) begin
                        r.data[i] = ~d[i];
                        hit = 1'b1;
                    end
                end
                r.fixed = hit;
                r.bad   = !hit;
            end
        end else if (syn != '0) begin
            r.bad = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ilv_row_dec.sv
module ilv_row_dec #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [DEPTH-1:0] sel
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign sel[g] = en && (addr == AW'(g));
    end
endmodule

// File: rtl/ilv_store.sv
module ilv_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  logic [W-1:0]  flip_mask,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] wsel;
    logic [DEPTH-1:0] fsel;

    ilv_row_dec #(.DEPTH(DEPTH)) i_wdec (.en(we),      .addr(waddr),     .sel(wsel));
    ilv_row_dec #(.DEPTH(DEPTH)) i_fdec (.en(flip_en), .addr(flip_addr), .sel(fsel));

    always_ff @(posedge clk) begin
        for (int r = 0; r < DEPTH; r++) begin
            if (wsel[r])      mem[r] <= wdata;
            else if (fsel[r]) mem[r] <= mem[r] ^ flip_mask;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ilv_secded_store.sv
module ilv_secded_store
    import ilv_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               tst_skew_wr,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_corrected,
    output logic               rd_uncorrectable,
    input  logic               flt_en,
    input  logic [AW-1:0]      flt_addr,
    input  logic [WORD_W-1:0]  flt_data_mask,
    input  logic [CHK_TOT-1:0] flt_chk_mask
);
    logic [CHK_TOT-1:0] wr_chk;
    logic [CHK_TOT-1:0] rd_chk;
    logic [WORD_W-1:0]  raw_word;
    logic [WORD_W-1:0]  fix_word;
    logic [AW-1:0]      chk_waddr;
    logic [NUM_HALF-1:0] half_fixed;
    logic [NUM_HALF-1:0] half_bad;

    assign chk_waddr = tst_skew_wr ? AW'(wr_addr + AW'(1)) : wr_addr;

    ilv_store #(.DEPTH(DEPTH), .W(WORD_W)) i_data_store (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .flip_en(flt_en), .flip_addr(flt_addr), .flip_mask(flt_data_mask),
        .raddr(rd_addr), .rdata(raw_word)
    );

    ilv_store #(.DEPTH(DEPTH), .W(CHK_TOT)) i_chk_store (
        .clk(clk), .we(wr_en), .waddr(chk_waddr), .wdata(wr_chk),
        .flip_en(flt_en), .flip_addr(flt_addr), .flip_mask(flt_chk_mask),
        .raddr(rd_addr), .rdata(rd_chk)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        half_t wr_half;
        half_t rd_half;
        dec_t  res;
        for (genvar i = 0; i < HALF_W; i++) begin : g_bit
            assign wr_half[i]               = wr_data[NUM_HALF*i + h];
            assign rd_half[i]               = raw_word[NUM_HALF*i + h];
            assign fix_word[NUM_HALF*i + h] = res.data[i];
        end
        assign wr_chk[h*CHK_W +: CHK_W] = encode(wr_half, fold_t'(wr_addr));
        assign res           = decode(rd_half, chk_t'(rd_chk[h*CHK_W +: CHK_W]), fold_t'(rd_addr));
        assign half_fixed[h] = res.fixed;
        assign half_bad[h]   = res.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid         <= 1'b0;
            rd_data          <= '0;
            rd_corrected     <= 1'b0;
            rd_uncorrectable <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data          <= fix_word;
                rd_corrected     <= |half_fixed;
                rd_uncorrectable <= |half_bad;
            end
        end
    end
endmodule

// File: rtl/ilv_secded_sva.sv
module ilv_secded_sva #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_en,
    input logic         rd_valid,
    input logic [W-1:0] rd_data,
    input logic         rd_corrected,
    input logic         rd_uncorrectable
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_idle_data_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

    p_idle_flags_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> ($stable(rd_corrected) && $stable(rd_uncorrectable)));

    p_reset_state_r7: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!rd_valid && rd_data == '0 && !rd_corrected && !rd_uncorrectable));
endmodule

bind ilv_secded_store ilv_secded_sva #(.W(ilv_pkg::WORD_W)) i_sva (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable)
);

// File: tb/test_ilv_secded_store.sv
module test_ilv_secded_store;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, tst_skew_wr = 1'b0, rd_en = 1'b0, flt_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, flt_addr = '0;
    logic [31:0] wr_data = '0, flt_data_mask = '0;
    logic [11:0] flt_chk_mask = '0;
    logic        rd_valid, rd_corrected, rd_uncorrectable;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] d;
        logic        c;
        logic        u;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ilv_secded_store #(.DEPTH(DEPTH)) i_ilv_secded_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tst_skew_wr(tst_skew_wr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrected(rd_corrected),
        .rd_uncorrectable(rd_uncorrectable), .flt_en(flt_en), .flt_addr(flt_addr),
        .flt_data_mask(flt_data_mask), .flt_chk_mask(flt_chk_mask)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] val(input int i);
        return 32'h5A3C_96E1 ^ (32'h0101_0101 * i) ^ (32'h8000_0000 >> i);
    endfunction

    task automatic wr(input int a, input logic [31:0] d, input bit skew);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; tst_skew_wr = skew;
        @(negedge clk);
        wr_en = 1'b0; tst_skew_wr = 1'b0;
    endtask

    task automatic inject(input int a, input logic [31:0] dm, input logic [11:0] cm);
        @(negedge clk);
        flt_en = 1'b1; flt_addr = AW'(a); flt_data_mask = dm; flt_chk_mask = cm;
        @(negedge clk);
        flt_en = 1'b0; flt_data_mask = '0; flt_chk_mask = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] d, input logic c, input logic u, input string tag);
        exp_t e;
        @(negedge clk);
        e.d = d; e.c = c; e.u = u; e.tag = tag;
        sb.push_back(e);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: pops expected results as the design produces them.
    always @(negedge clk) begin
        #1;
        if (!rst && rd_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rd_data == e.d, {e.tag, " data"}, rd_data, e.d);
                check(rd_corrected == e.c, {e.tag, " corrected"}, 32'(rd_corrected), 32'(e.c));
                check(rd_uncorrectable == e.u, {e.tag, " uncorrectable"}, 32'(rd_uncorrectable), 32'(e.u));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        repeat (4) @(negedge clk);
        #1;
        check(rd_valid == 1'b0 && rd_data == '0 && !rd_corrected && !rd_uncorrectable,
              "R7 state during reset", {rd_data[29:0], rd_corrected, rd_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(rd_valid == 1'b0 && rd_data == '0 && !rd_corrected && !rd_uncorrectable,
              "R7 state after reset", {rd_data[29:0], rd_corrected, rd_valid}, 32'd0);

        for (int i = 0; i < DEPTH; i++) wr(i, val(i), 1'b0);

        // R1: clean round trips, back-to-back reads
        rd(0, val(0), 1'b0, 1'b0, "R1 row0");
        rd(1, val(1), 1'b0, 1'b0, "R1 row1");
        rd(15, val(15), 1'b0, 1'b0, "R1 row15");
        wr(13, 32'h0000_0000, 1'b0);
        rd(13, 32'h0000_0000, 1'b0, 1'b0, "R1 zero word");
        wr(14, 32'hFFFF_FFFF, 1'b0);
        rd(14, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 ones word");

        // R8: outputs hold while idle
        repeat (2) @(negedge clk);
        hold = rd_data;
        repeat (3) @(negedge clk);
        #1;
        check(rd_valid == 1'b0, "R8 valid low when idle", 32'(rd_valid), 32'd0);
        check(rd_data == hold, "R8 data held when idle", rd_data, hold);

        // R2: single data bit flips
        inject(2, 32'h0000_0080, 12'h000);
        rd(2, val(2), 1'b1, 1'b0, "R2 bit7");
        inject(3, 32'h4000_0000, 12'h000);
        rd(3, val(3), 1'b1, 1'b0, "R2 bit30");
        wr(2, val(2), 1'b0);
        rd(2, val(2), 1'b0, 1'b0, "R1 rewrite clears fault");

        // R3: adjacent pairs straddle the halves
        inject(4, 32'h0000_3000, 12'h000);
        rd(4, val(4), 1'b1, 1'b0, "R3 bits12_13");
        inject(5, 32'hC000_0000, 12'h000);
        rd(5, val(5), 1'b1, 1'b0, "R3 bits30_31");
        inject(1, 32'h0000_0003, 12'h000);
        rd(1, val(1), 1'b1, 1'b0, "R3 bits0_1");

        // R4: double flip inside one half
        inject(6, 32'h0000_0005, 12'h000);
        rd(6, val(6) ^ 32'h0000_0005, 1'b0, 1'b1, "R4 even half bits0_2");
        inject(7, 32'h0000_000B, 12'h000);
        rd(7, val(7) ^ 32'h0000_000A, 1'b1, 1'b1, "R4 odd double even single");

        // R5: single check bit flips
        inject(8, 32'h0, 12'h001);
        rd(8, val(8), 1'b1, 1'b0, "R5 even ham bit");
        inject(9, 32'h0, 12'h020);
        rd(9, val(9), 1'b1, 1'b0, "R5 even overall bit");
        inject(10, 32'h0, 12'h100);
        rd(10, val(10), 1'b1, 1'b0, "R5 odd ham bit");

        // R6: check bits steered one row up
        wr(11, val(12), 1'b1);
        rd(12, val(12), 1'b0, 1'b1, "R6 skewed check row12");
        wr(15, val(0), 1'b1);
        rd(0, val(0), 1'b0, 1'b1, "R6 skewed check wraps to row0");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R1 all reads returned", 32'(sb.size()), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule